// File: doc/BRIEF.md
# Page-Selected Configuration Byte Streamer

This block feeds configuration images from a slow, word-addressed memory to downstream programmable devices. Eight images (pages) may be stored. A small option table, written once before use, gives each page a base address and a length in bytes. The images for all downstream devices sit back to back inside one page, so a single length covers them all.

When a start pulse arrives while the block is idle, it samples a 3-bit page selector and loads that page's base and length. It then fetches bytes one after another through a request/acknowledge read port whose latency may vary. A small first-in first-out buffer separates these fetches from a byte-wide valid/ready output. The output stalls whenever the buffer is empty, so a consumer that runs much faster than the memory simply waits. When the number of bytes delivered equals the page length, the block raises a done flag and returns to idle.

Top module: `cps_page_streamer`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after that edge, `busy`, `done`, `mem_req` and `out_valid` are all 0.
- R2: An accepted start uses the `page_sel` value n (binary, with 000 as the default page) to pick table entry n. The first byte delivered is the memory data at entry n's base address.
- R3: Bytes come out in order from the addresses base, base+1, and so on, with addresses wrapping modulo 2^ADDR_W. Each byte equals the memory data returned for its address.
- R4: Exactly `length` bytes are handed over. In the cycle after the last output handshake, `done` is 1, `busy` is 0 and `out_valid` is 0.
- R5: A start on a page of length 0 sets `done` to 1 and leaves `busy` at 0 right after the start edge. No `mem_req` and no `out_valid` appear.
- R6: While `busy` is 1, changes on `page_sel` and further `start` pulses have no effect on the bytes delivered or on their count.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` is held on the next cycle.
- R8: `mem_req` stays high, with `mem_addr` unchanged, until `mem_ack` arrives. At most one read is outstanding, and no more than FIFO_DEPTH fetched bytes wait undelivered.
- R9: When `tbl_we` is high at a clock edge, entry `tbl_idx` takes `tbl_base` and `tbl_len`. Table contents survive `rst_n`.
- R10: `done` stays 1 until the next accepted start. A new start on the same page delivers the same byte sequence again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Option table write enable |
| tbl_idx | input | PAGE_W | Option table entry to write |
| tbl_base | input | ADDR_W | Base address written into the entry |
| tbl_len | input | LEN_W | Byte length written into the entry |
| page_sel | input | PAGE_W | Page selector, sampled on an accepted start |
| start | input | 1 | Start pulse, accepted only while idle |
| busy | output | 1 | A page transfer is in progress |
| done | output | 1 | The last page transfer completed |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read address |
| mem_ack | input | 1 | Memory read acknowledge, data valid |
| mem_rdata | input | 8 | Memory read data |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | 8 | Output byte |

## Verification
The bench builds the block with ADDR_W=8, LEN_W=6 and FIFO_DEPTH=2. It programs all eight pages and sweeps every one of them under two consumer patterns, with read latency that varies by address. The two-entry buffer lets a stalled consumer fill the buffer within a few bytes, which exercises the full-buffer throttle. The 8-bit address lets one page cross the top of memory to check wrap-around. Zero-length, single-byte, disturbed, restarted and reset-interrupted runs are included, and every expected byte is computed arithmetically from its address.

// File: rtl/cps_pkg.sv
// Shared definitions for the page-selected configuration streamer.
// Assumes: output and memory data are one byte wide.
package cps_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;
endpackage

// File: rtl/cps_page_table.sv
// Option table: one base address and one byte length per page.
// Written through a simple port before use. Read combinationally by page index.
// Assumes: contents are not cleared by reset (programmed-once storage).
module cps_page_table #(
    parameter int PAGE_W = 3,
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [ADDR_W-1:0] rd_base,
    output logic [LEN_W-1:0]  rd_len
);
    localparam int NUM_PAGES = 1 << PAGE_W;

    logic [ADDR_W-1:0] base_q [NUM_PAGES];
    logic [LEN_W-1:0]  len_q  [NUM_PAGES];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            base_q[wr_idx] <= wr_base;
            len_q[wr_idx]  <= wr_len;
        end
    end

    // Present the selected entry.
    always_comb begin
        rd_base = base_q[rd_idx];
        rd_len  = len_q[rd_idx];
    end
endmodule

// File: rtl/cps_read_ctrl.sv
// Read sequencer: walks addresses from a loaded base for a loaded count.
// Keeps at most one request open and only issues one while the buffer has room.
// Assumes: load is pulsed only while no request is open.
module cps_read_ctrl #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_base,
    input  logic [LEN_W-1:0]  load_len,
    input  logic              room,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    output logic              push
);
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  left_q;
    logic              req_q;

    // Issue, hold and retire one read at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            left_q <= '0;
            req_q  <= 1'b0;
        end else if (load) begin
            addr_q <= load_base;
            left_q <= load_len;
            req_q  <= 1'b0;
        end else if (req_q && mem_ack) begin
            req_q  <= 1'b0;
            addr_q <= addr_q + ADDR_W'(1);
            left_q <= left_q - LEN_W'(1);
        end else if (!req_q && (left_q != '0) && room) begin
            req_q  <= 1'b1;
        end
    end

    // Drive the memory port and the buffer write strobe.
    always_comb begin
        mem_req  = req_q;
        mem_addr = addr_q;
        push     = req_q && mem_ack;
    end
endmodule

// File: rtl/cps_byte_fifo.sv
// Small first-word-fall-through byte buffer between memory and output.
// Assumes: the writer never pushes when full. A pop when empty is ignored.
module cps_byte_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DW-1:0]    store [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Qualify the strobes against occupancy.
    always_comb begin
        empty   = (count == '0);
        full    = (count == CNT_W'(DEPTH));
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        head    = store[rd_ptr];
    end

    // Write incoming bytes into storage.
    always_ff @(posedge clk) begin
        if (push_ok) store[wr_ptr] <= push_data;
    end

    // Advance pointers and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= step(wr_ptr);
            if (pop_ok)  rd_ptr <= step(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
        end
    end
endmodule

// File: rtl/cps_page_streamer.sv
// Top: samples the page selector on an idle start, loads base and length from
// the option table, fetches bytes through the read sequencer into the buffer,
// and counts handshakes on the byte output until the page length is reached.
// Assumes: memory data is one byte per address. A zero length finishes at once.
module cps_page_streamer
    import cps_pkg::*;
#(
    parameter int PAGE_W     = 3,
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 16,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [PAGE_W-1:0] tbl_idx,
    input  logic [ADDR_W-1:0] tbl_base,
    input  logic [LEN_W-1:0]  tbl_len,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);
    run_state_t        state_q;
    logic [LEN_W-1:0]  len_q, sent_q;
    logic              done_q;
    logic [ADDR_W-1:0] sel_base;
    logic [LEN_W-1:0]  sel_len;
    logic              accept, push, pop, buf_empty, buf_full;

    cps_page_table #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_table (
        .clk     (clk),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_base (tbl_base),
        .wr_len  (tbl_len),
        .rd_idx  (page_sel),
        .rd_base (sel_base),
        .rd_len  (sel_len)
    );

    cps_read_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_base (sel_base),
        .load_len  (sel_len),
        .room      (!buf_full),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .push      (push)
    );

    cps_byte_fifo #(.DEPTH(FIFO_DEPTH), .DW(BYTE_W)) u_buffer (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (mem_rdata),
        .pop       (pop),
        .head      (out_data),
        .empty     (buf_empty),
        .full      (buf_full)
    );

    // Decode start acceptance and output handshake.
    always_comb begin
        accept    = (state_q == ST_IDLE) && start;
        out_valid = !buf_empty;
        pop       = out_valid && out_ready;
        busy      = (state_q == ST_RUN);
        done      = done_q;
    end

    // Run control: latch the page on start, count delivered bytes, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            len_q   <= '0;
            sent_q  <= '0;
            done_q  <= 1'b0;
        end else if (accept) begin
            len_q   <= sel_len;
            sent_q  <= '0;
            done_q  <= (sel_len == '0);
            state_q <= (sel_len == '0) ? ST_IDLE : ST_RUN;
        end else if ((state_q == ST_RUN) && pop) begin
            sent_q <= sent_q + LEN_W'(1);
            if (sent_q + LEN_W'(1) == len_q) begin
                state_q <= ST_IDLE;
                done_q  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/cps_checker.sv
// Protocol checker for the streamer, attached through bind.
module cps_checker #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ack,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!busy && !done && !mem_req && !out_valid));

    p_quiet_output_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !out_valid);

    p_no_fetch_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    p_hold_stalled_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    p_hold_open_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_done_excludes_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_kept_until_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind cps_page_streamer cps_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/cps_page_streamer_bench.sv
module cps_page_streamer_bench;
    localparam int PAGE_W = 3;
    localparam int ADDR_W = 8;
    localparam int LEN_W  = 6;
    localparam int DEPTH  = 2;
    localparam time CLK_P = 8ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tbl_we = 1'b0;
    logic [PAGE_W-1:0] tbl_idx = '0;
    logic [ADDR_W-1:0] tbl_base = '0;
    logic [LEN_W-1:0]  tbl_len = '0;
    logic [PAGE_W-1:0] page_sel = '0;
    logic              start = 1'b0;
    logic              busy, done, mem_req, out_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_ack = 1'b0;
    logic [7:0]        mem_rdata = '0;
    logic              out_ready = 1'b0;
    logic [7:0]        out_data;

    int n_checks = 0;
    int n_fails  = 0;
    int n_push   = 0;
    int n_pop    = 0;
    bit finished = 1'b0;

    logic [ADDR_W-1:0] bases [8] = '{8'h10, 8'h40, 8'h00, 8'hFA, 8'h80, 8'h23, 8'hC0, 8'h55};
    int                lens  [8] = '{5, 0, 1, 9, 2, 12, 3, 7};

    always #(CLK_P/2) clk = ~clk;

    cps_page_streamer #(.PAGE_W(PAGE_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_DEPTH(DEPTH))
    u_cps_page_streamer (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
        .tbl_base(tbl_base), .tbl_len(tbl_len), .page_sel(page_sel), .start(start),
        .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data)
    );

    function automatic logic [7:0] mem_byte(input logic [ADDR_W-1:0] a);
        logic [7:0] t;
        t = 8'(a) * 8'd7 + 8'd3;
        return t ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Memory model: latency 0..2 cycles by address, one byte per address.
    initial begin
        forever begin
            @(negedge clk);
            mem_ack = 1'b0;
            if (rst_n && mem_req) begin
                repeat (int'(mem_addr) % 3) @(negedge clk);
                if (rst_n && mem_req) begin
                    mem_rdata = mem_byte(mem_addr);
                    mem_ack   = 1'b1;
                    n_push++;
                end
            end
        end
    end

    task automatic run_page(input int p, input int pat, input bit disturb, input string tag);
        logic [ADDR_W-1:0] base;
        int   len, k, cyc;
        bit   prev_stall;
        logic [7:0] prev_data;
        bit   r;
        base = bases[p];
        len  = lens[p];
        @(negedge clk);
        page_sel = PAGE_W'(p);
        start    = 1'b1;
        @(negedge clk);
        start    = 1'b0;
        page_sel = PAGE_W'(p ^ 3);
        if (len == 0) begin
            chk(done && !busy, "R5", {busy, done}, 1);
            for (int i = 0; i < 6; i++) begin
                chk(!mem_req && !out_valid, "R5", {mem_req, out_valid}, 0);
                @(negedge clk);
            end
            return;
        end
        chk(busy && !done, "R2", {busy, done}, 2);
        k = 0; cyc = 0; prev_stall = 1'b0; prev_data = '0;
        while (k < len && cyc < 2000) begin
            if (disturb && cyc == 2) start = 1'b1;
            if (disturb && cyc == 3) start = 1'b0;
            if (disturb) page_sel = PAGE_W'(cyc);
            r = (pat == 0) ? 1'b1 : (cyc % 3 == 0);
            if (prev_stall)
                chk(out_valid && out_data == prev_data, "R7", out_data, prev_data);
            chk(n_push - n_pop <= DEPTH, "R8", n_push - n_pop, DEPTH);
            if (out_valid && r) begin
                chk(out_data == mem_byte(ADDR_W'(base + ADDR_W'(k))),
                    (k == 0) ? "R2" : tag, out_data, mem_byte(ADDR_W'(base + ADDR_W'(k))));
                k++;
                n_pop++;
            end
            prev_stall = out_valid && !r;
            prev_data  = out_data;
            out_ready  = r;
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        chk(k == len, "R4", k, len);
        chk(done && !busy && !out_valid, "R4", {done, busy, out_valid}, 4);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(done && !out_valid && !mem_req, "R10", {done, out_valid, mem_req}, 4);
        end
    endtask

    initial begin
        // Program the option table.
        for (int p = 0; p < 8; p++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_idx = PAGE_W'(p);
            tbl_base = bases[p]; tbl_len = LEN_W'(lens[p]);
        end
        @(negedge clk);
        tbl_we = 1'b0;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !mem_req && !out_valid, "R1",
            {busy, done, mem_req, out_valid}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !out_valid, "R1",
            {busy, done, mem_req, out_valid}, 0);

        // Sweep all pages under both consumer patterns; odd pages are disturbed (R6).
        for (int pat = 0; pat < 2; pat++)
            for (int p = 0; p < 8; p++)
                run_page(p, pat, p[0], p[0] ? "R6" : (p == 3 ? "R3" : "R3"));

        // Restart the same page after done (R10).
        run_page(5, 1, 1'b0, "R10");
        run_page(5, 0, 1'b0, "R10");

        // Reset in the middle of a run (R1), then table retention (R9).
        @(negedge clk);
        page_sel = 3'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0; out_ready = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !out_valid, "R1",
            {busy, done, mem_req, out_valid}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        n_push = 0; n_pop = 0;
        @(negedge clk);
        chk(!busy && !done && !mem_req && !out_valid, "R1",
            {busy, done, mem_req, out_valid}, 0);
        run_page(3, 0, 1'b0, "R9");
        run_page(0, 1, 1'b0, "R9");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog.
    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule